// File: doc/BRIEF.md
# Event Number Alignment Checker

This block sits between the trigger fan-out and the event assembly stage of a multi-crate readout system. It forwards accepted trigger requests, with their type and the low byte of a 32-bit event counter, to nine readout crates and merges their busy flags. A trigger is forwarded only while a run is active, no crate is busy, no earlier event is still being collected and no alignment error is pending.

After each forwarded trigger the block collects one fragment header from every crate. A header carries a hardware event number (8 bits, the broadcast byte) and a software serial number (16 bits). Once all nine headers are in, each crate's pair is compared with the event number the block itself issued. Any disagreement, or a crate that stays silent for too long, latches an error with a mask naming the offending crates and the full expected event number, and raises a stop request. That request holds off further triggers until the next run start.

Top module: `evn_align_chk`

## Requirements
- R1: After reset all outputs are 0: no trigger, no busy (when no crate is busy), no run, no error, empty mask, expected number 0, no timeout flag, no stop request.
- R2: A trigger request sampled on a clock edge is forwarded as a one-cycle `trig_o` pulse, with `trig_type_o` registered from the request, only when a run is active, no crate is busy, no collection is in progress and no stop request is pending. Otherwise the request is dropped.
- R3: `trig_evn_o` carries the low 8 bits of the event number of the forwarded trigger. The first event after a run start is number 0, and each forwarded trigger adds one. The 8-bit field wraps from 255 to 0.
- R4: `busy_o` is high while any crate busy bit is high or a header collection is in progress. A collection runs from the trigger edge until completion or timeout.
- R5: Only the first header from each crate within a collection is captured. Repeated headers from that crate, and headers that arrive while no collection is in progress, have no effect.
- R6: When all nine captured headers match, no error is raised. Collection ends on the edge after the last header is captured, and the next trigger is accepted.
- R7: A crate mismatches when its hardware number differs from the low 8 bits of the event number, or its serial differs from the low 16 bits. On the edge after the last header is captured, any mismatch sets `err_o` and `stop_req_o`. The same edge loads `err_mask_o` (bit i = crate i) with the mismatching crates and loads `err_evn_o` with the full 32-bit event number.
- R8: If the nine headers are not all captured within 1024 cycles of the trigger, the block raises an error with `err_tmo_o` = 1 and a mask of the crates that never reported.
- R9: The error fields hold until `err_clr_i` or a run start. `err_clr_i` clears `err_o`, `err_mask_o`, `err_evn_o` and `err_tmo_o`. `stop_req_o` stays high, and triggers stay blocked, until a run start.
- R10: `run_start_i` activates the run, aborts any collection, clears all error state and the stop request, and resets the event counter to 0. It takes priority over a trigger request in the same cycle.
- R11: `run_stop_i` ends the run and aborts any collection. No trigger is forwarded while the run is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_start_i | input | 1 | Run start pulse |
| run_stop_i | input | 1 | Run stop pulse |
| err_clr_i | input | 1 | Clears latched error fields |
| trig_req_i | input | 1 | Candidate trigger from selection logic |
| trig_type_i | input | 3 | Type of candidate trigger |
| crate_busy_i | input | 9 | Busy flag per crate |
| hdr_vld_i | input | 9 | Header valid per crate |
| hdr_hw_i | input | 9x8 | Hardware event number per crate |
| hdr_ser_i | input | 9x16 | Software serial number per crate |
| trig_o | output | 1 | Forwarded trigger pulse |
| trig_type_o | output | 3 | Type of forwarded trigger |
| trig_evn_o | output | 8 | Low byte of the forwarded event number |
| busy_o | output | 1 | Combined busy |
| run_active_o | output | 1 | Run in progress |
| err_o | output | 1 | Latched alignment error |
| err_mask_o | output | 9 | Crates that mismatched or timed out |
| err_evn_o | output | 32 | Event number expected at the error |
| err_tmo_o | output | 1 | Error caused by header timeout |
| stop_req_o | output | 1 | Run stop request, held until run start |

## Verification
On every cycle the assertions check the trigger rules. A forwarded pulse must follow a request and a quiet busy line, must last a single cycle, must occur only during a run, and must never coincide with an error. They also check that busy follows each trigger, that an error implies a stop request, that a non-timeout error names at least one crate, that the error stays latched until cleared, and that a run start wipes it. Only the bench scenarios can show the values themselves. These cover the broadcast event byte across the 8-bit wrap, first-header-wins capture, the exact mask and event number for hardware and serial disagreements, the timeout mask of silent crates, and the split between clearing the error and releasing the stop request.

// File: rtl/evn_chk_pkg.sv
package evn_chk_pkg;
  parameter int unsigned N_CRATE_DEF = 9;
  parameter int unsigned EVN_W_DEF   = 32;
  parameter int unsigned HW_W_DEF    = 8;
  parameter int unsigned SER_W_DEF   = 16;
  parameter int unsigned TYPE_W_DEF  = 3;
  parameter int unsigned TMO_DEF     = 1024;

  typedef enum logic [0:0] {
    COL_IDLE = 1'b0,
    COL_WAIT = 1'b1
  } col_st_e;
endpackage

// File: rtl/evn_trig_gate.sv
module evn_trig_gate #(
  parameter int unsigned N_CRATE = 9,
  parameter int unsigned EVN_W   = 32,
  parameter int unsigned HW_W    = 8,
  parameter int unsigned TYPE_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_start_i,
  input  logic              run_stop_i,
  input  logic              trig_req_i,
  input  logic [TYPE_W-1:0] trig_type_i,
  input  logic [N_CRATE-1:0] crate_busy_i,
  input  logic              collecting_i,
  input  logic              lock_i,
  output logic              issue_o,
  output logic [EVN_W-1:0]  cur_evn_o,
  output logic              trig_o,
  output logic [TYPE_W-1:0] trig_type_o,
  output logic [HW_W-1:0]   trig_evn_o,
  output logic              run_active_o,
  output logic              busy_o
);
  logic [EVN_W-1:0] evn_q;
  logic             any_busy;

  assign any_busy = |crate_busy_i;
  assign issue_o  = trig_req_i & run_active_o & ~run_start_i & ~run_stop_i
                  & ~any_busy & ~collecting_i & ~lock_i;
  assign busy_o   = any_busy | collecting_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_active_o <= 1'b0;
      evn_q        <= '0;
      cur_evn_o    <= '0;
      trig_o       <= 1'b0;
      trig_type_o  <= '0;
      trig_evn_o   <= '0;
    end else begin
      trig_o <= issue_o;
      if (run_start_i) begin
        run_active_o <= 1'b1;
        evn_q        <= '0;
      end else begin
        if (run_stop_i) run_active_o <= 1'b0;
        if (issue_o) begin
          evn_q       <= evn_q + 1'b1;
          cur_evn_o   <= evn_q;
          trig_type_o <= trig_type_i;
          trig_evn_o  <= evn_q[HW_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/evn_hdr_capture.sv
module evn_hdr_capture #(
  parameter int unsigned N_CRATE = 9,
  parameter int unsigned HW_W    = 8,
  parameter int unsigned SER_W   = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic                          collecting_i,
  input  logic [N_CRATE-1:0]            hdr_vld_i,
  input  logic [N_CRATE-1:0][HW_W-1:0]  hdr_hw_i,
  input  logic [N_CRATE-1:0][SER_W-1:0] hdr_ser_i,
  output logic [N_CRATE-1:0]            cap_o,
  output logic [N_CRATE-1:0][HW_W-1:0]  hw_o,
  output logic [N_CRATE-1:0][SER_W-1:0] ser_o
);
  for (genvar g = 0; g < N_CRATE; g++) begin : g_crate
    logic take;
    assign take = collecting_i & hdr_vld_i[g] & ~cap_o[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cap_o[g] <= 1'b0;
        hw_o[g]  <= '0;
        ser_o[g] <= '0;
      end else if (start_i) begin
        cap_o[g] <= 1'b0;
      end else if (take) begin
        cap_o[g] <= 1'b1;
        hw_o[g]  <= hdr_hw_i[g];
        ser_o[g] <= hdr_ser_i[g];
      end
    end
  end
endmodule

// File: rtl/evn_col_ctrl.sv
module evn_col_ctrl
  import evn_chk_pkg::*;
#(
  parameter int unsigned TMO_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic abort_i,
  input  logic all_cap_i,
  output logic collecting_o,
  output logic done_o,
  output logic timeout_o
);
  localparam int unsigned TMR_W = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TMO_CYC - 1);

  col_st_e          st_q;
  logic [TMR_W-1:0] tmr_q;

  assign collecting_o = (st_q == COL_WAIT);
  assign done_o       = collecting_o & all_cap_i & ~abort_i;
  assign timeout_o    = collecting_o & ~all_cap_i & (tmr_q == TMR_LAST) & ~abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= COL_IDLE;
      tmr_q <= '0;
    end else if (abort_i) begin
      st_q  <= COL_IDLE;
      tmr_q <= '0;
    end else begin
      unique case (st_q)
        COL_IDLE: if (issue_i) begin
          st_q  <= COL_WAIT;
          tmr_q <= '0;
        end
        COL_WAIT: begin
          if (done_o || timeout_o) st_q <= COL_IDLE;
          else                     tmr_q <= tmr_q + 1'b1;
        end
        default: st_q <= COL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evn_err_latch.sv
module evn_err_latch #(
  parameter int unsigned N_CRATE = 9,
  parameter int unsigned EVN_W   = 32,
  parameter int unsigned HW_W    = 8,
  parameter int unsigned SER_W   = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          run_start_i,
  input  logic                          err_clr_i,
  input  logic                          done_i,
  input  logic                          timeout_i,
  input  logic [N_CRATE-1:0]            cap_i,
  input  logic [N_CRATE-1:0][HW_W-1:0]  hw_i,
  input  logic [N_CRATE-1:0][SER_W-1:0] ser_i,
  input  logic [EVN_W-1:0]              cur_evn_i,
  output logic                          err_o,
  output logic [N_CRATE-1:0]            mask_o,
  output logic [EVN_W-1:0]              evn_o,
  output logic                          tmo_o,
  output logic                          lock_o
);
  logic [N_CRATE-1:0] mism;
  logic [HW_W-1:0]    exp_hw;
  logic [SER_W-1:0]   exp_ser;

  assign exp_hw  = cur_evn_i[HW_W-1:0];
  assign exp_ser = cur_evn_i[SER_W-1:0];

  for (genvar g = 0; g < N_CRATE; g++) begin : g_cmp
    assign mism[g] = (hw_i[g] != exp_hw) | (ser_i[g] != exp_ser);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o  <= 1'b0;
      mask_o <= '0;
      evn_o  <= '0;
      tmo_o  <= 1'b0;
      lock_o <= 1'b0;
    end else if (run_start_i) begin
      err_o  <= 1'b0;
      mask_o <= '0;
      evn_o  <= '0;
      tmo_o  <= 1'b0;
      lock_o <= 1'b0;
    end else if (done_i && (|mism)) begin
      err_o  <= 1'b1;
      mask_o <= mism;
      evn_o  <= cur_evn_i;
      tmo_o  <= 1'b0;
      lock_o <= 1'b1;
    end else if (timeout_i) begin
      err_o  <= 1'b1;
      mask_o <= ~cap_i;
      evn_o  <= cur_evn_i;
      tmo_o  <= 1'b1;
      lock_o <= 1'b1;
    end else if (err_clr_i) begin
      err_o  <= 1'b0;
      mask_o <= '0;
      evn_o  <= '0;
      tmo_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/evn_align_chk.sv
module evn_align_chk
  import evn_chk_pkg::*;
#(
  parameter int unsigned N_CRATE = N_CRATE_DEF,
  parameter int unsigned EVN_W   = EVN_W_DEF,
  parameter int unsigned HW_W    = HW_W_DEF,
  parameter int unsigned SER_W   = SER_W_DEF,
  parameter int unsigned TYPE_W  = TYPE_W_DEF,
  parameter int unsigned TMO_CYC = TMO_DEF
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          run_start_i,
  input  logic                          run_stop_i,
  input  logic                          err_clr_i,
  input  logic                          trig_req_i,
  input  logic [TYPE_W-1:0]             trig_type_i,
  input  logic [N_CRATE-1:0]            crate_busy_i,
  input  logic [N_CRATE-1:0]            hdr_vld_i,
  input  logic [N_CRATE-1:0][HW_W-1:0]  hdr_hw_i,
  input  logic [N_CRATE-1:0][SER_W-1:0] hdr_ser_i,
  output logic                          trig_o,
  output logic [TYPE_W-1:0]             trig_type_o,
  output logic [HW_W-1:0]               trig_evn_o,
  output logic                          busy_o,
  output logic                          run_active_o,
  output logic                          err_o,
  output logic [N_CRATE-1:0]            err_mask_o,
  output logic [EVN_W-1:0]              err_evn_o,
  output logic                          err_tmo_o,
  output logic                          stop_req_o
);
  logic                          issue, collecting, done, timeout, abort;
  logic [EVN_W-1:0]              cur_evn;
  logic [N_CRATE-1:0]            cap;
  logic [N_CRATE-1:0][HW_W-1:0]  cap_hw;
  logic [N_CRATE-1:0][SER_W-1:0] cap_ser;

  assign abort = run_start_i | run_stop_i;

  evn_trig_gate #(
    .N_CRATE(N_CRATE), .EVN_W(EVN_W), .HW_W(HW_W), .TYPE_W(TYPE_W)
  ) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_start_i  (run_start_i),
    .run_stop_i   (run_stop_i),
    .trig_req_i   (trig_req_i),
    .trig_type_i  (trig_type_i),
    .crate_busy_i (crate_busy_i),
    .collecting_i (collecting),
    .lock_i       (stop_req_o),
    .issue_o      (issue),
    .cur_evn_o    (cur_evn),
    .trig_o       (trig_o),
    .trig_type_o  (trig_type_o),
    .trig_evn_o   (trig_evn_o),
    .run_active_o (run_active_o),
    .busy_o       (busy_o)
  );

  evn_col_ctrl #(.TMO_CYC(TMO_CYC)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .issue_i      (issue),
    .abort_i      (abort),
    .all_cap_i    (&cap),
    .collecting_o (collecting),
    .done_o       (done),
    .timeout_o    (timeout)
  );

  evn_hdr_capture #(.N_CRATE(N_CRATE), .HW_W(HW_W), .SER_W(SER_W)) u_cap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (issue | abort),
    .collecting_i (collecting & ~abort),
    .hdr_vld_i    (hdr_vld_i),
    .hdr_hw_i     (hdr_hw_i),
    .hdr_ser_i    (hdr_ser_i),
    .cap_o        (cap),
    .hw_o         (cap_hw),
    .ser_o        (cap_ser)
  );

  evn_err_latch #(
    .N_CRATE(N_CRATE), .EVN_W(EVN_W), .HW_W(HW_W), .SER_W(SER_W)
  ) u_err (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_start_i (run_start_i),
    .err_clr_i   (err_clr_i),
    .done_i      (done),
    .timeout_i   (timeout),
    .cap_i       (cap),
    .hw_i        (cap_hw),
    .ser_i       (cap_ser),
    .cur_evn_i   (cur_evn),
    .err_o       (err_o),
    .mask_o      (err_mask_o),
    .evn_o       (err_evn_o),
    .tmo_o       (err_tmo_o),
    .lock_o      (stop_req_o)
  );
endmodule

// File: rtl/evn_align_chk_sva.sv
module evn_align_chk_sva #(
  parameter int unsigned N_CRATE = 9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               run_start_i,
  input logic               err_clr_i,
  input logic               trig_req_i,
  input logic [N_CRATE-1:0] crate_busy_i,
  input logic               trig_o,
  input logic               busy_o,
  input logic               run_active_o,
  input logic               err_o,
  input logic               err_tmo_o,
  input logic [N_CRATE-1:0] err_mask_o,
  input logic               stop_req_o
);
  p_trig_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(trig_req_i) && ($past(crate_busy_i) == '0));

  p_trig_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  p_busy_after_trig_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> busy_o);

  p_trig_in_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> run_active_o);

  p_err_blocks_trig_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !trig_o);

  p_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !err_clr_i && !run_start_i |=> err_o);

  p_err_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> stop_req_o);

  p_err_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !err_tmo_o |-> err_mask_o != '0);

  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_start_i |=> !err_o && !stop_req_o && run_active_o);
endmodule

bind evn_align_chk evn_align_chk_sva #(.N_CRATE(N_CRATE)) u_sva (.*);

// File: tb/tb_evn_align_chk.sv
module tb_evn_align_chk;
  localparam int CLK_P = 10;
  localparam int NC    = 9;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              run_start_i = 1'b0, run_stop_i = 1'b0, err_clr_i = 1'b0;
  logic              trig_req_i = 1'b0;
  logic [2:0]        trig_type_i = '0;
  logic [NC-1:0]     crate_busy_i = '0;
  logic [NC-1:0]     hdr_vld_i = '0;
  logic [NC-1:0][7:0]  hdr_hw_i = '0;
  logic [NC-1:0][15:0] hdr_ser_i = '0;
  logic              trig_o, busy_o, run_active_o, err_o, err_tmo_o, stop_req_o;
  logic [2:0]        trig_type_o;
  logic [7:0]        trig_evn_o;
  logic [NC-1:0]     err_mask_o;
  logic [31:0]       err_evn_o;

  int errors = 0;
  int checks = 0;
  int unsigned exp_evn = 0;

  evn_align_chk dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic pulse_start();
    run_start_i = 1'b1; tick(); run_start_i = 1'b0;
    exp_evn = 0;
  endtask

  // request a trigger; returns whether trig_o was seen
  task automatic req_trig(input logic [2:0] t, output bit seen);
    trig_req_i = 1'b1; trig_type_i = t;
    tick();
    trig_req_i = 1'b0;
    seen = trig_o;
  endtask

  task automatic send_one(input int c, input logic [7:0] hw, input logic [15:0] ser);
    hdr_vld_i[c] = 1'b1; hdr_hw_i[c] = hw; hdr_ser_i[c] = ser;
    tick();
    hdr_vld_i = '0;
  endtask

  // send headers for enabled crates in shuffled order, then wait for compare edge
  task automatic send_set(input logic [NC-1:0][7:0] hw, input logic [NC-1:0][15:0] ser,
                          input logic [NC-1:0] en);
    int ord[NC];
    for (int i = 0; i < NC; i++) ord[i] = i;
    for (int i = NC-1; i > 0; i--) begin
      int j = int'($urandom_range(i, 0));
      int t = ord[i]; ord[i] = ord[j]; ord[j] = t;
    end
    for (int i = 0; i < NC; i++) begin
      if (en[ord[i]]) begin
        send_one(ord[i], hw[ord[i]], ser[ord[i]]);
        if ($urandom_range(3, 0) == 0) tick();
      end
    end
    tick();
  endtask

  function automatic logic [NC-1:0] exp_mism(input logic [NC-1:0][7:0] hw,
                                             input logic [NC-1:0][15:0] ser,
                                             input int unsigned evn);
    logic [NC-1:0] m;
    for (int i = 0; i < NC; i++)
      m[i] = (hw[i] != evn[7:0]) || (ser[i] != evn[15:0]);
    return m;
  endfunction

  task automatic good_hdrs(input int unsigned evn, output logic [NC-1:0][7:0] hw,
                           output logic [NC-1:0][15:0] ser);
    for (int i = 0; i < NC; i++) begin
      hw[i] = evn[7:0]; ser[i] = evn[15:0];
    end
  endtask

  // one clean event with checks of number and no error
  task automatic clean_event(input string tag);
    bit seen;
    logic [NC-1:0][7:0] hw;
    logic [NC-1:0][15:0] ser;
    logic [2:0] t = 3'($urandom_range(7, 0));
    req_trig(t, seen);
    chk(seen, "R2", {tag, " trig"}, seen, 1);
    chk(trig_type_o == t, "R2", {tag, " type"}, trig_type_o, t);
    chk(trig_evn_o == exp_evn[7:0], "R3", {tag, " evn"}, trig_evn_o, exp_evn[7:0]);
    good_hdrs(exp_evn, hw, ser);
    send_set(hw, ser, '1);
    chk(!err_o && !busy_o, "R6", {tag, " no err"}, {err_o, busy_o}, 0);
    exp_evn++;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit seen;
    logic [NC-1:0][7:0] hw;
    logic [NC-1:0][15:0] ser;
    logic [NC-1:0] m;
    void'($urandom(32'd4711));

    tick(); tick();
    chk({trig_o, busy_o, run_active_o, err_o, err_tmo_o, stop_req_o} == 0 &&
        err_mask_o == 0 && err_evn_o == 0 && trig_evn_o == 0,
        "R1", "reset state", {trig_o, busy_o, run_active_o, err_o}, 0);
    rst_ni = 1'b1;
    tick();

    req_trig(3'd1, seen);
    chk(!seen, "R11", "trig without run", seen, 0);

    pulse_start();
    chk(run_active_o, "R10", "run active", run_active_o, 1);

    // stray headers while idle are ignored
    good_hdrs(0, hw, ser);
    for (int i = 0; i < NC; i++) send_one(i, hw[i], ser[i]);
    req_trig(3'd2, seen);
    chk(seen && trig_evn_o == 8'd0, "R3", "first evn zero", trig_evn_o, 0);
    repeat (5) tick();
    chk(busy_o && !err_o, "R5", "stray hdrs not captured", {busy_o, err_o}, 2'b10);
    send_set(hw, ser, '1);
    chk(!busy_o && !err_o, "R6", "match done", {busy_o, err_o}, 0);
    exp_evn = 1;

    // repeated header from crate 0 ignored
    req_trig(3'd0, seen);
    good_hdrs(1, hw, ser);
    send_one(0, hw[0], ser[0]);
    send_one(0, 8'hEE, 16'hBEEF);
    send_set(hw, ser, 9'h1FE);
    chk(!err_o, "R5", "repeat hdr ignored", err_o, 0);
    exp_evn = 2;

    // busy gating
    crate_busy_i[4] = 1'b1;
    tick();
    chk(busy_o, "R4", "busy merge", busy_o, 1);
    req_trig(3'd3, seen);
    chk(!seen, "R2", "trig while busy", seen, 0);
    crate_busy_i = '0;

    // run across 8-bit wrap
    while (exp_evn < 258) clean_event("wrap");
    chk(exp_evn == 258 && !err_o, "R3", "wrap serial vs hw", err_o, 0);

    // hardware number mismatch on crate 5
    req_trig(3'd4, seen);
    good_hdrs(exp_evn, hw, ser);
    hw[5] = hw[5] + 8'd1;
    send_set(hw, ser, '1);
    chk(err_o && stop_req_o && err_mask_o == 9'h020 && !err_tmo_o, "R7", "hw mismatch mask",
        err_mask_o, 9'h020);
    chk(err_evn_o == exp_evn, "R7", "err evn", err_evn_o, exp_evn);
    req_trig(3'd0, seen);
    chk(!seen, "R9", "trig blocked on err", seen, 0);
    err_clr_i = 1'b1; tick(); err_clr_i = 1'b0;
    chk(!err_o && err_mask_o == 0 && err_evn_o == 0 && stop_req_o, "R9", "clear keeps stop",
        {err_o, stop_req_o}, 2'b01);
    req_trig(3'd0, seen);
    chk(!seen, "R9", "still blocked after clear", seen, 0);

    pulse_start();
    chk(!stop_req_o && !err_o, "R10", "restart clears", stop_req_o, 0);

    // serial mismatch on crates 0 and 8
    req_trig(3'd5, seen);
    chk(trig_evn_o == 8'd0, "R10", "counter reset", trig_evn_o, 0);
    good_hdrs(0, hw, ser);
    ser[0] = 16'h0100; ser[8] = 16'h0001;
    send_set(hw, ser, '1);
    chk(err_o && err_mask_o == 9'h101, "R7", "serial mismatch mask", err_mask_o, 9'h101);

    // timeout with crates 2 and 8 silent
    pulse_start();
    req_trig(3'd6, seen);
    good_hdrs(0, hw, ser);
    send_set(hw, ser, 9'h0FB);
    repeat (980) tick();
    chk(!err_o && busy_o, "R8", "no early timeout", err_o, 0);
    repeat (60) tick();
    chk(err_o && err_tmo_o && err_mask_o == 9'h104 && err_evn_o == 0, "R8", "timeout mask",
        err_mask_o, 9'h104);

    // run stop
    pulse_start();
    run_stop_i = 1'b1; tick(); run_stop_i = 1'b0;
    chk(!run_active_o, "R11", "run stopped", run_active_o, 0);
    req_trig(3'd1, seen);
    chk(!seen, "R11", "no trig after stop", seen, 0);

    // random phase
    pulse_start();
    for (int ev = 0; ev < 150; ev++) begin
      if ($urandom_range(4, 0) == 0) begin
        crate_busy_i = NC'($urandom_range(511, 1));
        req_trig(3'd0, seen);
        chk(!seen, "R2", "rand busy drop", seen, 0);
        crate_busy_i = '0;
      end
      req_trig(3'($urandom_range(7, 0)), seen);
      chk(seen && trig_evn_o == exp_evn[7:0], "R3", "rand evn", trig_evn_o, exp_evn[7:0]);
      good_hdrs(exp_evn, hw, ser);
      if ($urandom_range(5, 0) == 0) begin
        int c = int'($urandom_range(NC-1, 0));
        if ($urandom_range(1, 0) == 0) hw[c] = hw[c] ^ 8'(1 << $urandom_range(7, 0));
        else ser[c] = ser[c] ^ 16'(1 << $urandom_range(15, 0));
      end
      m = exp_mism(hw, ser, exp_evn);
      send_set(hw, ser, '1);
      chk(err_o == (m != 0) && err_mask_o == m, "R7", "rand mask", err_mask_o, m);
      if (m != 0) begin
        chk(err_evn_o == exp_evn, "R7", "rand err evn", err_evn_o, exp_evn);
        pulse_start();
      end else begin
        exp_evn++;
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule